// File: doc/BRIEF.md
# Associative Multicast Packet Router

The router takes at most one packet per clock. It looks up the packet's routing key in a table of entries that are all compared at the same time. Each entry has a key, a mask and a port vector. A matching entry sends a copy of the packet to every port in its vector. The ports are six inter-chip links, numbered 0 to 5 around a hexagon, followed by `N_LOCAL` ports for local processors. When no entry matches, a packet that arrived on a link goes straight across to the link opposite.

If a chosen link has no room, its copy is sent to the next link around the hexagon and marked as an emergency copy. Every emergency use raises a one-cycle pulse for the local monitor. A copy is dropped only when there is nowhere to send it, and each packet that loses a copy increments a saturating drop counter. Software fills the table through a plain write port.

Back-pressure rules:
- The input side of the stream is valid/ready, but `in_ready` is high at all times after reset. The router never pushes back on its input.
- The output side runs on credit. `out_ready[p]` tells the router that port `p` can take one packet in the following cycle. The router samples `out_ready[p]` in the cycle it accepts a packet.
- `out_valid[p]` is a one-cycle pulse in the next cycle. The receiver must take it, because it already declared room for it.
- All output ports share `out_key` and `out_payload`.

Top module: `mc_router`

## Requirements
- R1: After reset, `out_valid`, `out_emerg` and `emerg_irq` are 0, `drop_cnt` is 0 and every table entry is invalid. Key and mask words reset to 0.
- R2: An entry matches when it is valid and (packet key AND entry mask) equals the entry key. Invalid entries never match.
- R3: When several entries match, the entry with the lowest index decides the route.
- R4: A packet accepted in cycle t appears in cycle t+1 on every port of the chosen vector whose `out_ready` was high in cycle t, with `out_key` and `out_payload` equal to the accepted packet. With no accepted packet, `out_valid` is 0 in the next cycle.
- R5: When no entry matches a packet that arrived on link i (`in_src` 0 to 5), the packet goes to link (i+3) mod 6.
- R6: When no entry matches a packet from a local source (`in_src` of 6 or more), the packet is dropped and the drop count rises by one.
- R7: When a chosen link i is not ready but link (i+1) mod 6 is ready, the copy goes to (i+1) mod 6. The matching bit of `out_emerg` is set, and `emerg_irq` pulses in the same cycle as the copy.
- R8: When a chosen link and its alternative are both not ready, that copy is dropped and the drop count rises by one. The router sends no emergency copy and raises no pulse for that copy.
- R9: A copy for a local port that is not ready is dropped and the drop count rises by one. This rule is applied once per packet, however many of its copies are lost.
- R10: `in_ready` is high in every cycle after reset, including back-to-back packets.
- R11: Table writes use the `tbl_sel` codes 0 = key word, 1 = mask word, 2 = port vector (also marks the entry valid), 3 = invalidate. A packet accepted in the same cycle as a write sees the old table; the write applies from the next cycle on.
- R12: `drop_cnt` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Router can accept a packet (high after reset) |
| in_key | input | KEY_W | Routing key |
| in_payload | input | PAY_W | Packet payload |
| in_src | input | SRC_W | Arrival port: 0-5 links, 6 and up local |
| out_valid | output | NPORT | Per-port one-cycle packet strobe |
| out_ready | input | NPORT | Per-port room for one packet next cycle |
| out_emerg | output | NPORT | Per-port emergency-copy flag |
| out_key | output | KEY_W | Key of the emitted packet |
| out_payload | output | PAY_W | Payload of the emitted packet |
| emerg_irq | output | 1 | Pulse: an emergency copy was sent |
| drop_cnt | output | DROP_W | Saturating count of packets that lost a copy |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | ADDR_W | Table entry index |
| tbl_sel | input | 2 | Word select (see R11) |
| tbl_wdata | input | KEY_W | Write data; the vector uses the low NPORT bits |

## Verification
Every routing result, emergency flag, monitor pulse and drop-count change is due exactly one clock after the packet is accepted. Each check therefore drives a packet on a falling edge and reads the outputs on the next falling edge, which comes after the single register stage has updated. A table write is driven on a falling edge, and it is tested by packets sent on that same edge and on the following one, to show the old/new boundary. In the back-to-back run, each falling edge checks the previous packet's outputs before the next packet is driven.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned LINKS = 6;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_KILL = 2'd3
  } tbl_sel_e;

  // link straight across the hexagon
  function automatic int unsigned link_opp(input int unsigned i);
    return (i + 3) % LINKS;
  endfunction

  // neighbouring link that closes the triangle around link i
  function automatic int unsigned link_alt(input int unsigned i);
    return (i + 1) % LINKS;
  endfunction
endpackage

// File: rtl/mcr_table.sv
module mcr_table
  import mcr_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned KEY_W     = 32,
  parameter int unsigned VEC_W     = 10,
  parameter int unsigned AW        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       sel,
  input  logic [KEY_W-1:0] wdata,
  input  logic [KEY_W-1:0] lk_key,
  output logic             hit,
  output logic [VEC_W-1:0] vec
);
  logic [KEY_W-1:0] key_q  [N_ENTRIES];
  logic [KEY_W-1:0] mask_q [N_ENTRIES];
  logic [VEC_W-1:0] vec_q  [N_ENTRIES];
  logic [N_ENTRIES-1:0] vld_q;
  logic [N_ENTRIES-1:0] match;
  logic [AW-1:0] win;
  logic addr_ok;

  assign addr_ok = (int'(addr) < N_ENTRIES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENTRIES; e++) begin
        key_q[e]  <= '0;
        mask_q[e] <= '0;
        vec_q[e]  <= '0;
      end
      vld_q <= '0;
    end else if (we && addr_ok) begin
      unique case (tbl_sel_e'(sel))
        SEL_KEY:  key_q[addr]  <= wdata;
        SEL_MASK: mask_q[addr] <= wdata;
        SEL_VEC: begin
          vec_q[addr] <= wdata[VEC_W-1:0];
          vld_q[addr] <= 1'b1;
        end
        SEL_KILL: vld_q[addr] <= 1'b0;
        default: ;
      endcase
    end
  end

  // every entry compares at once
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign match[e] = vld_q[e] && ((lk_key & mask_q[e]) == key_q[e]);
  end

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int e = N_ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) begin
        hit = 1'b1;
        win = AW'(e);
      end
    end
  end

  assign vec = vec_q[win];

  assert_vec_sets_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr_ok && sel == 2'd2) |=> vld_q[$past(addr)]);

  assert_kill_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr_ok && sel == 2'd3) |=> !vld_q[$past(addr)]);
endmodule

// File: rtl/mcr_route.sv
module mcr_route
  import mcr_pkg::*;
#(
  parameter int unsigned N_LOCAL = 4,
  parameter int unsigned NPORT   = LINKS + N_LOCAL,
  parameter int unsigned SRC_W   = $clog2(NPORT)
) (
  input  logic             hit,
  input  logic [NPORT-1:0] vec,
  input  logic [SRC_W-1:0] src,
  input  logic [NPORT-1:0] rdy,
  output logic [NPORT-1:0] send,
  output logic [NPORT-1:0] emerg,
  output logic             drop
);
  logic [NPORT-1:0] want;
  logic lost;
  logic local_miss;

  always_comb begin
    want = '0;
    if (hit) want = vec;
    else if (int'(src) < LINKS) want[link_opp(int'(src))] = 1'b1;
    local_miss = !hit && (int'(src) >= LINKS);
  end

  always_comb begin
    emerg = '0;
    lost  = 1'b0;
    for (int unsigned i = 0; i < LINKS; i++) begin
      if (want[i] && !rdy[i]) begin
        if (rdy[link_alt(i)]) emerg[link_alt(i)] = 1'b1;
        else                  lost = 1'b1;
      end
    end
    for (int unsigned j = LINKS; j < NPORT; j++) begin
      if (want[j] && !rdy[j]) lost = 1'b1;
    end
  end

  assign send = (want & rdy) | emerg;
  assign drop = lost | local_miss;
endmodule

// File: rtl/mc_router.sv
module mc_router
  import mcr_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned KEY_W     = 32,
  parameter int unsigned PAY_W     = 32,
  parameter int unsigned N_LOCAL   = 4,
  parameter int unsigned DROP_W    = 16,
  localparam int unsigned NPORT    = LINKS + N_LOCAL,
  localparam int unsigned SRC_W    = $clog2(NPORT),
  localparam int unsigned ADDR_W   = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [PAY_W-1:0]  in_payload,
  input  logic [SRC_W-1:0]  in_src,
  output logic [NPORT-1:0]  out_valid,
  input  logic [NPORT-1:0]  out_ready,
  output logic [NPORT-1:0]  out_emerg,
  output logic [KEY_W-1:0]  out_key,
  output logic [PAY_W-1:0]  out_payload,
  output logic              emerg_irq,
  output logic [DROP_W-1:0] drop_cnt,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [1:0]        tbl_sel,
  input  logic [KEY_W-1:0]  tbl_wdata
);
  logic             hit;
  logic [NPORT-1:0] vec;
  logic [NPORT-1:0] send;
  logic [NPORT-1:0] emerg;
  logic             drop;

  mcr_table #(
    .N_ENTRIES(N_ENTRIES), .KEY_W(KEY_W), .VEC_W(NPORT), .AW(ADDR_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .addr(tbl_addr), .sel(tbl_sel),
    .wdata(tbl_wdata), .lk_key(in_key), .hit(hit), .vec(vec)
  );

  mcr_route #(.N_LOCAL(N_LOCAL), .NPORT(NPORT), .SRC_W(SRC_W)) u_route (
    .hit(hit), .vec(vec), .src(in_src), .rdy(out_ready),
    .send(send), .emerg(emerg), .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready    <= 1'b0;
      out_valid   <= '0;
      out_emerg   <= '0;
      emerg_irq   <= 1'b0;
      out_key     <= '0;
      out_payload <= '0;
      drop_cnt    <= '0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= in_valid ? send : '0;
      out_emerg <= in_valid ? emerg : '0;
      emerg_irq <= in_valid && (|emerg);
      if (in_valid) begin
        out_key     <= in_key;
        out_payload <= in_payload;
      end
      if (in_valid && drop && !(&drop_cnt)) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  assert_no_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_ready);

  assert_idle_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (out_valid == '0));

  assert_only_ready_ports_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_valid & ~$past(out_ready)) == '0));

  assert_emerg_is_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_emerg & ~out_valid) == '0);

  assert_irq_has_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    emerg_irq |-> (out_emerg != '0));

  assert_drop_monotonic_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_cnt >= $past(drop_cnt)));
endmodule

// File: tb/sim_mc_router.sv
module sim_mc_router;
  localparam int NP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_key = '0;
  logic [31:0] in_payload = '0;
  logic [3:0] in_src = '0;
  logic [NP-1:0] out_valid;
  logic [NP-1:0] out_ready = '1;
  logic [NP-1:0] out_emerg;
  logic [31:0] out_key;
  logic [31:0] out_payload;
  logic emerg_irq;
  logic [3:0] drop_cnt;
  logic tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [1:0] tbl_sel = '0;
  logic [31:0] tbl_wdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int exp_drop = 0;
  int cyc = 0;

  mc_router #(.N_ENTRIES(16), .KEY_W(32), .PAY_W(32), .N_LOCAL(4), .DROP_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_payload(in_payload), .in_src(in_src),
    .out_valid(out_valid), .out_ready(out_ready), .out_emerg(out_emerg),
    .out_key(out_key), .out_payload(out_payload), .emerg_irq(emerg_irq),
    .drop_cnt(drop_cnt), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      summary();
    end
  end

  task automatic twr(input int addr, input int sel, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'(addr); tbl_sel = 2'(sel); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // drive one packet, then check outputs one cycle later
  task automatic pkt(input string req, input logic [31:0] key, input int src,
                     input logic [NP-1:0] rdy, input logic [NP-1:0] ev,
                     input logic [NP-1:0] ee, input logic eirq, input logic drp);
    logic [31:0] pay;
    pay = key ^ 32'hA5A5_0000 ^ 32'(src);
    @(negedge clk);
    in_valid = 1'b1; in_key = key; in_src = 4'(src); in_payload = pay; out_ready = rdy;
    @(negedge clk);
    in_valid = 1'b0; out_ready = '1;
    if (drp && exp_drop < 15) exp_drop++;
    chk({req, " out_valid"}, 32'(out_valid), 32'(ev));
    chk({req, " out_emerg"}, 32'(out_emerg), 32'(ee));
    chk({req, " emerg_irq"}, 32'(emerg_irq), 32'(eirq));
    chk({req, " drop_cnt"}, 32'(drop_cnt), 32'(exp_drop));
    if (ev != '0) begin
      chk({req, " out_key"}, out_key, key);
      chk({req, " out_payload"}, out_payload, pay);
    end
  endtask

  task automatic t_reset();
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 emerg", 32'(out_emerg), 0);
    chk("R1 irq", 32'(emerg_irq), 0);
    chk("R1 drop", 32'(drop_cnt), 0);
    chk("R10 in_ready", 32'(in_ready), 1);
    // empty table: miss from link 1 goes to link 4
    pkt("R1 R5 empty table", 32'h1234, 1, '1, 10'h010, '0, 1'b0, 1'b0);
  endtask

  task automatic t_match();
    twr(2, 0, 32'h0000_1200);
    twr(2, 1, 32'hFFFF_FF00);
    twr(2, 2, 32'h0000_0081);
    pkt("R2 R4 R11 multicast", 32'h0000_1234, 3, '1, 10'h081, '0, 1'b0, 1'b0);
    pkt("R2 R5 mask miss", 32'h0000_1334, 3, '1, 10'h001, '0, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    twr(1, 0, 32'h0000_1000);
    twr(1, 1, 32'hFFFF_F000);
    twr(1, 2, 32'h0000_0002);
    pkt("R3 lowest wins", 32'h0000_1234, 4, '1, 10'h002, '0, 1'b0, 1'b0);
    twr(1, 3, 32'h0);
    pkt("R11 invalidate", 32'h0000_1234, 4, '1, 10'h081, '0, 1'b0, 1'b0);
  endtask

  task automatic t_emerg();
    pkt("R7 reroute 0->1", 32'h0000_1234, 3, 10'h3FE, 10'h082, 10'h002, 1'b1, 1'b0);
    pkt("R5 R7 miss 5->0", 32'h0000_9999, 2, 10'h3DF, 10'h001, 10'h001, 1'b1, 1'b0);
  endtask

  task automatic t_drops();
    pkt("R8 link and alt blocked", 32'h0000_1234, 3, 10'h3FC, 10'h080, '0, 1'b0, 1'b1);
    pkt("R9 local blocked", 32'h0000_1234, 3, 10'h37F, 10'h001, '0, 1'b0, 1'b1);
    pkt("R6 local miss", 32'hABCD_0000, 6, '1, '0, '0, 1'b0, 1'b1);
  endtask

  task automatic t_back2back();
    logic [31:0] ks [3];
    int srcs [3];
    logic [NP-1:0] evs [3];
    ks[0] = 32'h0000_1234; srcs[0] = 3; evs[0] = 10'h081;
    ks[1] = 32'h0000_9999; srcs[1] = 4; evs[1] = 10'h002;
    ks[2] = 32'h0000_12FF; srcs[2] = 5; evs[2] = 10'h081;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk("R4 R10 stream out_valid", 32'(out_valid), 32'(evs[k-1]));
        chk("R4 stream key", out_key, ks[k-1]);
        chk("R10 stream in_ready", 32'(in_ready), 1);
      end
      if (k < 3) begin
        in_valid = 1'b1; in_key = ks[k]; in_src = 4'(srcs[k]); in_payload = 32'(k);
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R4 idle", 32'(out_valid), 0);
  endtask

  task automatic t_write_edge();
    // entry 4 keeps its reset key/mask of 0; making it valid catches every key
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'd4; tbl_sel = 2'd2; tbl_wdata = 32'h0000_0200;
    in_valid = 1'b1; in_key = 32'h0000_5555; in_src = 4'd0; in_payload = 32'h1;
    @(negedge clk);
    tbl_we = 1'b0;
    chk("R11 same-cycle old table", 32'(out_valid), 32'h008);
    in_key = 32'h0000_5555; in_payload = 32'h2;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 R11 next-cycle new entry", 32'(out_valid), 32'h200);
    twr(4, 3, 32'h0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 20; k++)
      pkt("R12 saturate", 32'hDEAD_0000, 7, '1, '0, '0, 1'b0, 1'b1);
    chk("R12 drop at max", 32'(drop_cnt), 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_priority();
    t_emerg();
    t_drops();
    t_back2back();
    t_write_edge();
    t_saturate();
    summary();
  end
endmodule